// File: doc/BRIEF.md
# Configurable Three-Table Logic Cell

This block models a single programmable logic cell. Two 4-input lookup tables produce the first-level results, and a 3-input mixing table combines both of those results with one extra input. With these three tables the cell can realise two independent 4-variable functions plus a 3-variable function. It can also form any 5-variable function, when both first-level tables see the same four inputs and the mixing table picks between them on the fifth. Wider functions such as 9-input parity also fit. Two flip-flops can each capture one selected combinational result, gated by a clock enable. A synchronous reset returns each flip-flop to its own configured start value.

Before normal use, all configuration bits are shifted in serially while `cfgDone` is low, and every output stays low during that time. After `cfgDone` is raised, the configuration is frozen. If configuration selects RAM mode, the 32 bits of the two 4-input tables can be written one bit at a time on the clock, and any bit can be read combinationally.

Top module: `lut_logic_cell`

## Requirements
- R1: While `cfgDone` is low, `fOut`, `gOut`, `hOut`, `q0`, `q1` and `ramRdata` are all 0.
- R2: On a rising `clk` with `cfgShift` high and `cfgDone` low, `cfgData` enters a 47-bit chain. After 47 shifts, the first bit sent sits at bit 0. The layout is: [15:0] first table, [31:16] second table, [39:32] mixing table, [41:40] source of flip-flop 0, [43:42] source of flip-flop 1, [44] start value of flip-flop 0, [45] start value of flip-flop 1, [46] RAM mode.
- R3: Shift requests made while `cfgDone` is high leave the configuration unchanged.
- R4: `fOut` equals bit `fIn` of the first table, and `gOut` equals bit `gIn` of the second table.
- R5: `hOut` equals bit {`hExtra`, g, f} of the mixing table (index = 4·hExtra + 2·g + f), where f and g are the two first-level results.
- R6: On a rising `clk` with `ce` high and `srst` low, a flip-flop loads its selected source: code 0 selects f, 1 selects g, 2 selects the mixing result, and 3 selects `hExtra`. With `ce` low, the flip-flop holds its value.
- R7: `srst` loads each flip-flop's start value and takes priority over `ce`. While `cfgDone` is low, the flip-flops also load their start values, so `q0`/`q1` show those values in the first cycle after `cfgDone` rises.
- R8: With `cfgDone` high and RAM mode set, `ramWe` writes `ramWdata` at the clock edge into chain bit `ramAddr` (0–15 in the first table, 16–31 in the second). The new value also changes `fOut`/`gOut`.
- R9: With RAM mode clear, `ramWe` has no effect on any table.
- R10: `ramRdata` shows chain bit `ramAddr` combinationally while `cfgDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock (configuration shift, RAM writes, flip-flops) |
| srst | input | 1 | Synchronous reset of the flip-flops to their start values |
| ce | input | 1 | Flip-flop clock enable |
| cfgShift | input | 1 | Shift one configuration bit |
| cfgData | input | 1 | Serial configuration bit |
| cfgDone | input | 1 | Configuration complete; enables outputs |
| fIn | input | 4 | First-table inputs |
| gIn | input | 4 | Second-table inputs |
| hExtra | input | 1 | Extra input of the mixing table |
| ramWe | input | 1 | RAM write enable |
| ramAddr | input | 5 | RAM bit address |
| ramWdata | input | 1 | RAM write data |
| fOut | output | 1 | First-table result |
| gOut | output | 1 | Second-table result |
| hOut | output | 1 | Mixing-table result |
| q0 | output | 1 | Registered output 0 |
| q1 | output | 1 | Registered output 1 |
| ramRdata | output | 1 | RAM read data |

## Verification
A wrongly placed or corrupted configuration bit appears at a combinational output in the same cycle that an input pattern addresses it. A bad flip-flop state appears at `q0`/`q1` one edge after the capture that caused it. A misaligned shift chain shows up in the first cycle after `cfgDone` rises, through the flip-flop start values and the table outputs. A RAM write that lands on the wrong bit, or that should have been blocked, is visible on `ramRdata` and on `fOut`/`gOut` in the cycle right after the edge.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

  typedef struct packed {
    logic shiftEn;
    logic ramWrite;
    logic ffLoad;
    logic ffReset;
    logic live;
  } cellStrobes_t;

  localparam int SRC_W = 2;
  localparam logic [SRC_W-1:0] SRC_F   = 2'd0;
  localparam logic [SRC_W-1:0] SRC_G   = 2'd1;
  localparam logic [SRC_W-1:0] SRC_H   = 2'd2;
  localparam logic [SRC_W-1:0] SRC_EXT = 2'd3;

endpackage

// File: rtl/lutcell_ctrl.sv
module lutcell_ctrl
  import lutcell_pkg::*;
(
  input  logic         cfgShift,
  input  logic         cfgDone,
  input  logic         ramMode,
  input  logic         ramWe,
  input  logic         ce,
  input  logic         srst,
  output cellStrobes_t st
);

  always_comb begin
    st.live     = cfgDone;
    st.shiftEn  = cfgShift & ~cfgDone;
    st.ramWrite = cfgDone & ramMode & ramWe;
    st.ffReset  = srst | ~cfgDone;
    st.ffLoad   = cfgDone & ce;
  end

endmodule

// File: rtl/lutcell_dp.sv
module lutcell_dp
  import lutcell_pkg::*;
#(
  parameter int LUT_IN = 4
) (
  input  logic              clk,
  input  cellStrobes_t      st,
  input  logic              cfgData,
  input  logic [LUT_IN-1:0] fIn,
  input  logic [LUT_IN-1:0] gIn,
  input  logic              hExtra,
  input  logic [LUT_IN:0]   ramAddr,
  input  logic              ramWdata,
  output logic              fOut,
  output logic              gOut,
  output logic              hOut,
  output logic              q0,
  output logic              q1,
  output logic              ramRdata,
  output logic              ramMode
);

  localparam int TBL    = 1 << LUT_IN;
  localparam int MIX_IN = 3;
  localparam int HTBL   = 1 << MIX_IN;
  localparam int OFF_H  = 2 * TBL;
  localparam int OFF_S  = OFF_H + HTBL;
  localparam int OFF_I  = OFF_S + 2 * SRC_W;
  localparam int OFF_RM = OFF_I + 2;
  localparam int CFG_W  = OFF_RM + 1;

  logic [CFG_W-1:0]  cfgReg;
  logic [LUT_IN-1:0] lutIdx [2];
  logic [1:0]        lutRaw;
  logic [HTBL-1:0]   hTable;
  logic [MIX_IN-1:0] hIdx;
  logic              hRaw;
  logic [1:0]        qReg;

  // Configuration chain; the F/G part doubles as user RAM after loading.
  always_ff @(posedge clk) begin
    if (st.shiftEn)
      cfgReg <= {cfgData, cfgReg[CFG_W-1:1]};
    else if (st.ramWrite)
      cfgReg[ramAddr] <= ramWdata;
  end

  assign lutIdx[0] = fIn;
  assign lutIdx[1] = gIn;

  for (genvar k = 0; k < 2; k++) begin : g_lut
    logic [TBL-1:0] table_k;
    assign table_k   = cfgReg[k*TBL +: TBL];
    assign lutRaw[k] = table_k[lutIdx[k]];
  end

  assign hTable = cfgReg[OFF_H +: HTBL];
  assign hIdx   = {hExtra, lutRaw[1], lutRaw[0]};
  assign hRaw   = hTable[hIdx];

  for (genvar j = 0; j < 2; j++) begin : g_ff
    logic [SRC_W-1:0] srcSel;
    logic             startVal;
    logic             dIn;
    assign srcSel   = cfgReg[OFF_S + j*SRC_W +: SRC_W];
    assign startVal = cfgReg[OFF_I + j];
    always_comb begin
      unique case (srcSel)
        SRC_F:   dIn = lutRaw[0];
        SRC_G:   dIn = lutRaw[1];
        SRC_H:   dIn = hRaw;
        default: dIn = hExtra;
      endcase
    end
    always_ff @(posedge clk) begin
      if (st.ffReset)
        qReg[j] <= startVal;
      else if (st.ffLoad)
        qReg[j] <= dIn;
    end
  end

  assign ramMode  = cfgReg[OFF_RM];
  assign fOut     = st.live & lutRaw[0];
  assign gOut     = st.live & lutRaw[1];
  assign hOut     = st.live & hRaw;
  assign q0       = st.live & qReg[0];
  assign q1       = st.live & qReg[1];
  assign ramRdata = st.live & cfgReg[ramAddr];

endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell
  import lutcell_pkg::*;
#(
  parameter int LUT_IN = 4
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              ce,
  input  logic              cfgShift,
  input  logic              cfgData,
  input  logic              cfgDone,
  input  logic [LUT_IN-1:0] fIn,
  input  logic [LUT_IN-1:0] gIn,
  input  logic              hExtra,
  input  logic              ramWe,
  input  logic [LUT_IN:0]   ramAddr,
  input  logic              ramWdata,
  output logic              fOut,
  output logic              gOut,
  output logic              hOut,
  output logic              q0,
  output logic              q1,
  output logic              ramRdata
);

  cellStrobes_t st;
  logic         ramModeW;

  lutcell_ctrl u_ctrl (
    .cfgShift (cfgShift),
    .cfgDone  (cfgDone),
    .ramMode  (ramModeW),
    .ramWe    (ramWe),
    .ce       (ce),
    .srst     (srst),
    .st       (st)
  );

  lutcell_dp #(.LUT_IN(LUT_IN)) u_dp (
    .clk      (clk),
    .st       (st),
    .cfgData  (cfgData),
    .fIn      (fIn),
    .gIn      (gIn),
    .hExtra   (hExtra),
    .ramAddr  (ramAddr),
    .ramWdata (ramWdata),
    .fOut     (fOut),
    .gOut     (gOut),
    .hOut     (hOut),
    .q0       (q0),
    .q1       (q1),
    .ramRdata (ramRdata),
    .ramMode  (ramModeW)
  );

endmodule

// File: rtl/lutcell_chk.sv
module lutcell_chk
  import lutcell_pkg::*;
#(
  parameter int LUT_IN = 4
) (
  input logic            clk,
  input logic            srst,
  input logic            ce,
  input logic            cfgDone,
  input logic [LUT_IN:0] ramAddr,
  input logic            ramWdata,
  input logic            fOut,
  input logic            gOut,
  input logic            hOut,
  input logic            q0,
  input logic            q1,
  input logic            ramRdata,
  input cellStrobes_t    st,
  input logic            ramMode
);

  assert_dark_unconfigured_R1: assert property (@(posedge clk) disable iff (srst)
    !cfgDone |-> ({fOut, gOut, hOut, q0, q1, ramRdata} == 6'b0));

  assert_hold_without_enable_R6: assert property (@(posedge clk) disable iff (srst)
    (cfgDone && $past(cfgDone) && !$past(srst) && !$past(ce)) |-> ($stable(q0) && $stable(q1)));

  assert_ram_write_lands_R8: assert property (@(posedge clk) disable iff (srst)
    (cfgDone && $past(st.ramWrite) && (ramAddr == $past(ramAddr))) |-> (ramRdata == $past(ramWdata)));

  assert_logic_mode_no_write_R9: assert property (@(posedge clk) disable iff (srst)
    (cfgDone && $past(cfgDone) && !$past(ramMode) && (ramAddr == $past(ramAddr))) |-> $stable(ramRdata));

endmodule

bind lut_logic_cell lutcell_chk #(.LUT_IN(LUT_IN)) chk (
  .clk      (clk),
  .srst     (srst),
  .ce       (ce),
  .cfgDone  (cfgDone),
  .ramAddr  (ramAddr),
  .ramWdata (ramWdata),
  .fOut     (fOut),
  .gOut     (gOut),
  .hOut     (hOut),
  .q0       (q0),
  .q1       (q1),
  .ramRdata (ramRdata),
  .st       (st),
  .ramMode  (ramModeW)
);

// File: tb/lut_logic_cell_test.sv
`timescale 1ns/1ps
module lut_logic_cell_test;

  localparam int CW = 47;

  logic clk = 1'b0;
  logic srst = 1'b1, ce = 1'b0, cfgShift = 1'b0, cfgData = 1'b0, cfgDone = 1'b0;
  logic [3:0] fIn = '0, gIn = '0;
  logic hExtra = 1'b0, ramWe = 1'b0, ramWdata = 1'b0;
  logic [4:0] ramAddr = '0;
  logic fOut, gOut, hOut, q0, q1, ramRdata;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  bit [CW-1:0] mc = '0;
  bit mq0 = 0, mq1 = 0;

  always #4 clk = ~clk;

  lut_logic_cell uut (
    .clk(clk), .srst(srst), .ce(ce), .cfgShift(cfgShift), .cfgData(cfgData),
    .cfgDone(cfgDone), .fIn(fIn), .gIn(gIn), .hExtra(hExtra), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .fOut(fOut), .gOut(gOut),
    .hOut(hOut), .q0(q0), .q1(q1), .ramRdata(ramRdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit [CW-1:0] mkCfg(bit [15:0] f, bit [15:0] g, bit [7:0] h,
                                        bit [1:0] s0, bit [1:0] s1, bit i0, bit i1, bit rm);
    return {rm, i1, i0, s1, s0, h, g, f};
  endfunction

  task automatic check(string what, string tag, string phase, logic act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s [%s]: actual=%b expected=%b", tag, what, phase, act, exp);
    end
  endtask

  function automatic bit pickSrc(bit [1:0] s, bit f, bit g, bit h, bit e);
    case (s)
      2'd0: return f;
      2'd1: return g;
      2'd2: return h;
      default: return e;
    endcase
  endfunction

  // one clock: compare now, advance the model, move to next falling edge
  task automatic tick(string phase);
    bit live, fr, gr, hr, n0, n1;
    #1;
    live = cfgDone;
    fr = mc[fIn];
    gr = mc[16 + gIn];
    hr = mc[32 + {hExtra, gr, fr}];
    if (live) begin
      check("fOut", "R4", phase, fOut, fr);
      check("gOut", "R4", phase, gOut, gr);
      check("hOut", "R5", phase, hOut, hr);
      check("q0", "R6 R7", phase, q0, mq0);
      check("q1", "R6 R7", phase, q1, mq1);
      check("ramRdata", "R10 R8", phase, ramRdata, mc[ramAddr]);
    end else begin
      check("fOut", "R1", phase, fOut, 0);
      check("gOut", "R1", phase, gOut, 0);
      check("hOut", "R1", phase, hOut, 0);
      check("q0", "R1", phase, q0, 0);
      check("q1", "R1", phase, q1, 0);
      check("ramRdata", "R1", phase, ramRdata, 0);
    end
    n0 = mq0; n1 = mq1;
    if (srst || !cfgDone) begin
      n0 = mc[44]; n1 = mc[45];
    end else if (ce) begin
      n0 = pickSrc(mc[41:40], fr, gr, hr, hExtra);
      n1 = pickSrc(mc[43:42], fr, gr, hr, hExtra);
    end
    if (cfgShift && !cfgDone) mc = {cfgData, mc[CW-1:1]};
    else if (cfgDone && mc[46] && ramWe) mc[ramAddr] = ramWdata;
    mq0 = n0; mq1 = n1;
    @(posedge clk);
    @(negedge clk);
  endtask

  // R2: bit 0 shifted first
  task automatic loadCfg(bit [CW-1:0] w);
    cfgDone = 0;
    for (int i = 0; i < CW; i++) begin
      cfgShift = 1; cfgData = w[i];
      tick("R2 load");
    end
    cfgShift = 0; cfgData = 0;
    tick("R2 settle");
  endtask

  initial begin
    @(negedge clk);
    // reset state, unconfigured
    for (int i = 0; i < 3; i++) tick("R1 reset");

    // 9-input parity: F,G parity4, H xor3; q0<-H, q1<-F, starts 1/0
    loadCfg(mkCfg(16'h6996, 16'h6996, 8'h96, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0));
    cfgDone = 1; srst = 0;
    tick("R7 start values");
    for (int i = 0; i < 256; i++) begin
      fIn = i[3:0]; gIn = i[7:4]; hExtra = i[0] ^ i[5];
      ce = i[1] | i[6]; srst = (i % 37 == 5);
      ramWe = 1; ramAddr = 5'(i * 7); ramWdata = ~mc[5'(i * 7)];
      tick("R9 logic mode");
    end
    ramWe = 0; srst = 0;

    // R3: shifting after completion is ignored
    for (int i = 0; i < 20; i++) begin
      cfgShift = 1; cfgData = $urandom_range(0, 1);
      fIn = 4'($urandom); gIn = 4'($urandom); hExtra = $urandom_range(0, 1);
      ce = $urandom_range(0, 1);
      tick("R3 frozen");
    end
    cfgShift = 0;

    // 5-input function via mux in H; q0<-G, q1<-hExtra, starts 0/1; RAM mode
    loadCfg(mkCfg(16'h8000, 16'hFFFE, 8'hCA, 2'd1, 2'd3, 1'b0, 1'b1, 1'b1));
    cfgDone = 1;
    tick("R7 start values");
    for (int i = 0; i < 32; i++) begin
      ramWe = 1; ramAddr = 5'(i); ramWdata = i[0] ^ i[2];
      fIn = 4'(i); gIn = 4'(i); hExtra = i[4]; ce = 1;
      tick("R8 fill");
    end
    for (int i = 0; i < 300; i++) begin
      ramWe = $urandom_range(0, 1); ramAddr = 5'($urandom); ramWdata = $urandom_range(0, 1);
      fIn = 4'($urandom); gIn = fIn; hExtra = $urandom_range(0, 1);
      ce = $urandom_range(0, 1); srst = ($urandom_range(0, 15) == 0);
      tick("R8 R6 RAM mode");
    end
    ramWe = 0; srst = 0;
    cfgDone = 0;
    for (int i = 0; i < 3; i++) tick("R1 dark again");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule